// File: doc/BRIEF.md
# Transmit Descriptor Write-Back Tracker

This block follows each transmit descriptor from the moment it is accepted until the moment it may be reported back to the host. Descriptors come in on a valid/ready stream, one record per beat. Each record carries a kind (data, context or null), a byte length, a report-status flag and a segmentation flag. The tracker places every descriptor in a bounded in-order queue. For each data descriptor it issues internal fetch requests to a DMA engine: a segmentation send is cut into fixed-size chunks, and any other data descriptor goes out as one request. Every request carries the queue slot as a tag. The DMA engine returns one completion per request, with that tag, so a completion always decrements the outstanding count of the descriptor that issued it and of no other.

When the oldest queued descriptor has no fetches outstanding, it retires. If its report-status flag is set, it first presents a write-back request that carries its ring index and the size of the write: the status byte alone, or the whole 16-byte descriptor. All three streams follow the same back-pressure rules. A source that raises valid keeps valid and its payload unchanged until ready is seen high at a clock edge. No output valid depends combinationally on any ready input. When the queue holds `DEPTH` entries, `desc_ready` falls and incoming descriptors wait. No write-back is dropped and none is issued in a different form.

Top module: `txwb_tracker`

## Requirements
- R1: A data descriptor (kind 2'b00) with a non-zero length and the segmentation flag set issues ceil(len/CHUNK) fetch requests in order. Every request carries CHUNK bytes except the last, which carries the remainder. Without the segmentation flag, the descriptor issues exactly one request for its whole length.
- R2: A write-back for a descriptor is presented only after every fetch completion belonging to that descriptor has been received.
- R3: A descriptor whose report-status flag is clear never produces a write-back, but it still retires in order.
- R4: Context (2'b01), null (2'b10), reserved (2'b11) and zero-length data descriptors issue no fetch request. With the report-status flag set, they are written back as soon as they reach the head of the queue, without waiting for any fetch completion.
- R5: The write-back size is 1 byte when `wb_thresh` is 0 and 16 bytes when `wb_thresh` is 1 or more. The value of `wb_thresh` is captured at the cycle the descriptor is accepted.
- R6: Write-backs appear in descriptor acceptance order. `wb_index` is a ring index that starts at 0 after reset and increases by one for each accepted descriptor, modulo 2^IDX_W.
- R7: A completion is credited only to the descriptor whose request carried that tag. A data descriptor that directly follows a segmentation send is not written back until its own fetch has completed.
- R8: While `DEPTH` descriptors are pending, `desc_ready` is low and the offered descriptor is held rather than lost. It is accepted once an entry retires.
- R9: On the fetch and write-back streams, valid stays high and the payload stays constant while ready is low.
- R10: After reset, `desc_ready` is high and `freq_valid` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_thresh | input | TH_W | Write-back threshold; zero selects status-byte write-back, non-zero selects full write-back |
| desc_valid | input | 1 | Descriptor record offered |
| desc_ready | output | 1 | Tracker can accept a descriptor |
| desc_kind | input | 2 | 00 data, 01 context, 10 null, 11 reserved (no data) |
| desc_len | input | LEN_W | Buffer length in bytes |
| desc_rs | input | 1 | Report-status flag |
| desc_seg | input | 1 | Segmentation-send flag |
| freq_valid | output | 1 | Fetch request offered |
| freq_ready | input | 1 | DMA engine takes the fetch request |
| freq_tag | output | log2(DEPTH) | Queue slot of the requesting descriptor |
| freq_len | output | LEN_W | Bytes in this fetch request |
| fdone_valid | input | 1 | One fetch request has completed (always accepted) |
| fdone_tag | input | log2(DEPTH) | Tag of the completed request |
| wb_valid | output | 1 | Write-back request offered |
| wb_ready | input | 1 | Host side takes the write-back |
| wb_index | output | IDX_W | Ring index of the descriptor to write back |
| wb_bytes | output | 5 | Write-back size: 1 or 16 |

## Verification
If an outstanding-fetch count is wrong, or a completion is credited to the wrong slot, a write-back appears at the ports before the bench has delivered every completion for that descriptor. The check at the write-back handshake reports this in the same cycle. A pointer that slips shows up as a write-back with the wrong index, a missing one, or an extra one for a descriptor without report status, and the first affected handshake is flagged. A wrong chunk counter shows up at the next fetch handshake as a length that differs from the bench's own split. A mode latched at the wrong time shows up as a wrong size on that descriptor's write-back.

// File: rtl/twb_pkg.sv
package twb_pkg;

  typedef enum logic [1:0] {
    DK_DATA     = 2'b00,
    DK_CONTEXT  = 2'b01,
    DK_NULL     = 2'b10,
    DK_RESERVED = 2'b11
  } desc_kind_e;

  localparam int unsigned WB_SIZE_W = 5;
  localparam logic [WB_SIZE_W-1:0] WB_STATUS_ONLY = 5'd1;
  localparam logic [WB_SIZE_W-1:0] WB_WHOLE_DESC  = 5'd16;

endpackage

// File: rtl/twb_req_count.sv
module twb_req_count #(
  parameter int LEN_W    = 16,
  parameter int CHUNK_LG = 8,
  parameter int CNT_W    = LEN_W - CHUNK_LG + 1
) (
  input  logic [1:0]       kind,
  input  logic [LEN_W-1:0] len,
  input  logic             seg,
  output logic             has_data,
  output logic [CNT_W-1:0] reqs
);
  import twb_pkg::*;

  localparam logic [LEN_W:0] ROUND_UP = (LEN_W+1)'((1 << CHUNK_LG) - 1);

  desc_kind_e     k;
  logic [LEN_W:0] padded;

  always_comb begin
    k        = desc_kind_e'(kind);
    has_data = (k == DK_DATA) && (len != '0);
    padded   = {1'b0, len} + ROUND_UP;
    if (!has_data)  reqs = '0;
    else if (seg)   reqs = padded[LEN_W:CHUNK_LG];
    else            reqs = CNT_W'(1);
  end
endmodule

// File: rtl/twb_slot_queue.sv
module twb_slot_queue #(
  parameter int DEPTH = 8,
  parameter int LEN_W = 16,
  parameter int IDX_W = 8,
  parameter int CNT_W = 9,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  // allocation
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [LEN_W-1:0] alloc_len,
  input  logic             alloc_seg,
  input  logic             alloc_data,
  input  logic             alloc_rs,
  input  logic             alloc_whole,
  input  logic [CNT_W-1:0] alloc_reqs,
  output logic             full,
  output logic [PTR_W:0]   wr_ptr,
  // view for the fetch issuer
  input  logic [PTR_W:0]   iss_ptr,
  output logic [LEN_W-1:0] iss_len,
  output logic             iss_seg,
  output logic             iss_data,
  // completion credit
  input  logic             cred_en,
  input  logic [PTR_W-1:0] cred_tag,
  // head
  output logic             head_done,
  output logic [IDX_W-1:0] head_idx,
  output logic             head_rs,
  output logic             head_whole,
  input  logic             pop_en
);

  logic [IDX_W-1:0] s_idx   [DEPTH];
  logic [LEN_W-1:0] s_len   [DEPTH];
  logic [CNT_W-1:0] s_left  [DEPTH];
  logic             s_seg   [DEPTH];
  logic             s_data  [DEPTH];
  logic             s_rs    [DEPTH];
  logic             s_whole [DEPTH];
  logic             s_busy  [DEPTH];

  logic [PTR_W:0]   rd_ptr;
  logic [PTR_W:0]   fill;
  logic [PTR_W-1:0] wr_slot, rd_slot, iss_slot;

  assign wr_slot  = wr_ptr[PTR_W-1:0];
  assign rd_slot  = rd_ptr[PTR_W-1:0];
  assign iss_slot = iss_ptr[PTR_W-1:0];
  assign fill     = wr_ptr - rd_ptr;
  assign full     = (fill == (PTR_W+1)'(DEPTH));

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          s_idx[g]   <= '0;
          s_len[g]   <= '0;
          s_left[g]  <= '0;
          s_seg[g]   <= 1'b0;
          s_data[g]  <= 1'b0;
          s_rs[g]    <= 1'b0;
          s_whole[g] <= 1'b0;
          s_busy[g]  <= 1'b0;
        end else if (alloc_en && (wr_slot == PTR_W'(g))) begin
          s_idx[g]   <= alloc_idx;
          s_len[g]   <= alloc_len;
          s_left[g]  <= alloc_reqs;
          s_seg[g]   <= alloc_seg;
          s_data[g]  <= alloc_data;
          s_rs[g]    <= alloc_rs;
          s_whole[g] <= alloc_whole;
          s_busy[g]  <= 1'b1;
        end else begin
          if (cred_en && (cred_tag == PTR_W'(g)))
            s_left[g] <= s_left[g] - CNT_W'(1);
          if (pop_en && (rd_slot == PTR_W'(g)))
            s_busy[g] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (alloc_en) wr_ptr <= wr_ptr + 1'b1;
      if (pop_en)   rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_comb begin
    iss_len    = s_len[iss_slot];
    iss_seg    = s_seg[iss_slot];
    iss_data   = s_data[iss_slot];
    head_idx   = s_idx[rd_slot];
    head_rs    = s_rs[rd_slot];
    head_whole = s_whole[rd_slot];
    head_done  = (rd_ptr != wr_ptr) && (s_left[rd_slot] == '0) && (iss_ptr != rd_ptr);
  end

  // R8: the occupancy never exceeds the queue depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (PTR_W+1)'(DEPTH));

  // R7: a completion must land on a live slot that still expects one
  a_r7_credit_live: assert property (@(posedge clk) disable iff (!rst_n)
    cred_en |-> (s_busy[cred_tag] && (s_left[cred_tag] != '0)));

  // R6: retirement only ever takes an occupied head
  a_r6_pop_occupied: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> s_busy[rd_slot]);

  // R2: the retiring head has no fetch left outstanding
  a_r2_pop_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> (s_left[rd_slot] == '0));

endmodule

// File: rtl/twb_fetch_issuer.sv
module twb_fetch_issuer #(
  parameter int DEPTH = 8,
  parameter int LEN_W = 16,
  parameter int CHUNK = 256,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W:0]   wr_ptr,
  input  logic [LEN_W-1:0] ent_len,
  input  logic             ent_seg,
  input  logic             ent_data,
  output logic [PTR_W:0]   iss_ptr,
  output logic             freq_valid,
  input  logic             freq_ready,
  output logic [PTR_W-1:0] freq_tag,
  output logic [LEN_W-1:0] freq_len
);

  localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK);

  logic [LEN_W-1:0] left_q;
  logic             mid_q;
  logic             have;
  logic [LEN_W-1:0] cur_left, chunk, rest;
  logic             take;

  always_comb begin
    have       = (iss_ptr != wr_ptr);
    cur_left   = mid_q ? left_q : ent_len;
    chunk      = (ent_seg && (cur_left > CHUNK_L)) ? CHUNK_L : cur_left;
    rest       = cur_left - chunk;
    freq_valid = have && ent_data;
    take       = freq_valid && freq_ready;
    freq_tag   = iss_ptr[PTR_W-1:0];
    freq_len   = chunk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_ptr <= '0;
      left_q  <= '0;
      mid_q   <= 1'b0;
    end else if (have && !ent_data) begin
      iss_ptr <= iss_ptr + 1'b1;
    end else if (take) begin
      if (rest == '0) begin
        iss_ptr <= iss_ptr + 1'b1;
        mid_q   <= 1'b0;
      end else begin
        left_q  <= rest;
        mid_q   <= 1'b1;
      end
    end
  end

  // R9: a stalled fetch request keeps its tag and length
  a_r9_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_valid && !freq_ready) |=> (freq_valid && $stable(freq_tag) && $stable(freq_len)));

  // R1: segmentation chunks are non-empty and never larger than CHUNK
  a_r1_chunk_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_valid && ent_seg) |-> ((freq_len != '0) && (freq_len <= CHUNK_L)));

  // R1: the issuer never runs ahead of allocation
  a_r1_issuer_behind_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_ptr - iss_ptr) <= (PTR_W+1)'(DEPTH)));

endmodule

// File: rtl/txwb_tracker.sv
module txwb_tracker #(
  parameter int DEPTH = 8,
  parameter int LEN_W = 16,
  parameter int IDX_W = 8,
  parameter int CHUNK = 256,
  parameter int TH_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TH_W-1:0]          wb_thresh,
  input  logic                     desc_valid,
  output logic                     desc_ready,
  input  logic [1:0]               desc_kind,
  input  logic [LEN_W-1:0]         desc_len,
  input  logic                     desc_rs,
  input  logic                     desc_seg,
  output logic                     freq_valid,
  input  logic                     freq_ready,
  output logic [$clog2(DEPTH)-1:0] freq_tag,
  output logic [LEN_W-1:0]         freq_len,
  input  logic                     fdone_valid,
  input  logic [$clog2(DEPTH)-1:0] fdone_tag,
  output logic                     wb_valid,
  input  logic                     wb_ready,
  output logic [IDX_W-1:0]         wb_index,
  output logic [4:0]               wb_bytes
);
  import twb_pkg::*;

  localparam int PTR_W    = $clog2(DEPTH);
  localparam int CHUNK_LG = $clog2(CHUNK);
  localparam int CNT_W    = LEN_W - CHUNK_LG + 1;

  logic             q_full;
  logic [PTR_W:0]   wr_ptr, iss_ptr;
  logic [LEN_W-1:0] iss_len;
  logic             iss_seg, iss_data;
  logic             head_done, head_rs, head_whole;
  logic [IDX_W-1:0] head_idx;
  logic             alloc_en, pop_en;
  logic             new_data;
  logic [CNT_W-1:0] new_reqs;
  logic [IDX_W-1:0] next_idx;
  logic             mode_whole;

  assign desc_ready = !q_full;
  assign alloc_en   = desc_valid && desc_ready;
  assign mode_whole = (wb_thresh != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        next_idx <= '0;
    else if (alloc_en) next_idx <= next_idx + 1'b1;
  end

  twb_req_count #(.LEN_W(LEN_W), .CHUNK_LG(CHUNK_LG), .CNT_W(CNT_W)) u_count (
    .kind     (desc_kind),
    .len      (desc_len),
    .seg      (desc_seg),
    .has_data (new_data),
    .reqs     (new_reqs)
  );

  twb_slot_queue #(.DEPTH(DEPTH), .LEN_W(LEN_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_en    (alloc_en),
    .alloc_idx   (next_idx),
    .alloc_len   (desc_len),
    .alloc_seg   (desc_seg),
    .alloc_data  (new_data),
    .alloc_rs    (desc_rs),
    .alloc_whole (mode_whole),
    .alloc_reqs  (new_reqs),
    .full        (q_full),
    .wr_ptr      (wr_ptr),
    .iss_ptr     (iss_ptr),
    .iss_len     (iss_len),
    .iss_seg     (iss_seg),
    .iss_data    (iss_data),
    .cred_en     (fdone_valid),
    .cred_tag    (fdone_tag),
    .head_done   (head_done),
    .head_idx    (head_idx),
    .head_rs     (head_rs),
    .head_whole  (head_whole),
    .pop_en      (pop_en)
  );

  twb_fetch_issuer #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CHUNK(CHUNK)) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ptr     (wr_ptr),
    .ent_len    (iss_len),
    .ent_seg    (iss_seg),
    .ent_data   (iss_data),
    .iss_ptr    (iss_ptr),
    .freq_valid (freq_valid),
    .freq_ready (freq_ready),
    .freq_tag   (freq_tag),
    .freq_len   (freq_len)
  );

  always_comb begin
    wb_valid = head_done && head_rs;
    pop_en   = head_done && (!head_rs || wb_ready);
    wb_index = head_idx;
    wb_bytes = head_whole ? WB_WHOLE_DESC : WB_STATUS_ONLY;
  end

  // R9: a stalled write-back keeps its index and size
  a_r9_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_index) && $stable(wb_bytes)));

  // R5: only the two legal write-back sizes ever appear
  a_r5_wb_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ((wb_bytes == WB_STATUS_ONLY) || (wb_bytes == WB_WHOLE_DESC)));

  // R8: a full queue refuses the offered descriptor and keeps refusing until a retirement
  a_r8_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready && !pop_en) |=> !desc_ready);

endmodule

// File: tb/txwb_tracker_test.sv
module txwb_tracker_test;
  localparam int DEPTH = 8;
  localparam int LEN_W = 16;
  localparam int IDX_W = 8;
  localparam int CHUNK = 256;
  localparam int TH_W  = 4;
  localparam int PTR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TH_W-1:0] wb_thresh = '0;
  logic desc_valid = 1'b0, desc_ready;
  logic [1:0] desc_kind = '0;
  logic [LEN_W-1:0] desc_len = '0;
  logic desc_rs = 1'b0, desc_seg = 1'b0;
  logic freq_valid, freq_ready = 1'b0;
  logic [PTR_W-1:0] freq_tag;
  logic [LEN_W-1:0] freq_len;
  logic fdone_valid = 1'b0;
  logic [PTR_W-1:0] fdone_tag = '0;
  logic wb_valid, wb_ready = 1'b0;
  logic [IDX_W-1:0] wb_index;
  logic [4:0] wb_bytes;

  always #4 clk = ~clk;

  txwb_tracker #(.DEPTH(DEPTH), .LEN_W(LEN_W), .IDX_W(IDX_W), .CHUNK(CHUNK), .TH_W(TH_W)) uut (
    .clk(clk), .rst_n(rst_n), .wb_thresh(wb_thresh),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_kind(desc_kind),
    .desc_len(desc_len), .desc_rs(desc_rs), .desc_seg(desc_seg),
    .freq_valid(freq_valid), .freq_ready(freq_ready), .freq_tag(freq_tag), .freq_len(freq_len),
    .fdone_valid(fdone_valid), .fdone_tag(fdone_tag),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_index(wb_index), .wb_bytes(wb_bytes)
  );

  typedef struct { int kind; int len; bit rs; bit seg; } stim_t;
  typedef struct { int seq; int len; } fexp_t;
  typedef struct { int seq; int bytes; } wexp_t;
  typedef struct { int tag; int seq; int due; } resp_t;

  stim_t stim_q[$];
  fexp_t fexp_q[$];
  wexp_t wexp_q[$];
  resp_t resp_q[$];
  int need_cpl[int];
  int got_cpl[int];

  int seq_n = 0, cyc = 0, checks = 0, fails = 0, last_due = 0;
  int fr_pct = 100, wr_pct = 100, lat_min = 1, lat_max = 4;
  bit resp_hold = 1'b0;
  bit p_fv = 0, p_fr = 0, p_wv = 0, p_wr = 0;
  int p_ftag = 0, p_flen = 0, p_widx = 0, p_wbytes = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic accept(input stim_t s);
    int sq, n, rem, c;
    sq = seq_n; seq_n++; n = 0;
    if (s.kind == 0 && s.len != 0) begin
      if (s.seg) begin
        rem = s.len;
        while (rem > 0) begin
          c = (rem > CHUNK) ? CHUNK : rem;
          fexp_q.push_back('{sq, c});
          rem -= c; n++;
        end
      end else begin
        fexp_q.push_back('{sq, s.len}); n = 1;
      end
    end
    need_cpl[sq] = n;
    got_cpl[sq] = 0;
    if (s.rs) wexp_q.push_back('{sq, (wb_thresh != 0) ? 16 : 1});
  endtask

  task automatic step();
    bit fr, wr;
    @(negedge clk);
    cyc++;
    // R9: stalled streams must hold
    if (p_fv && !p_fr)
      chk(freq_valid && freq_tag == PTR_W'(p_ftag) && freq_len == LEN_W'(p_flen),
          "R9", "fetch request changed while stalled", int'(freq_len), p_flen);
    if (p_wv && !p_wr)
      chk(wb_valid && wb_index == IDX_W'(p_widx) && wb_bytes == 5'(p_wbytes),
          "R9", "write-back changed while stalled", int'(wb_index), p_widx);
    // fetch stream
    fr = ($urandom_range(99) < fr_pct);
    freq_ready = fr;
    if (freq_valid && fr) begin
      if (fexp_q.size() == 0) chk(1'b0, "R1 R4", "unexpected fetch request len", int'(freq_len), -1);
      else begin
        fexp_t f; int due;
        f = fexp_q.pop_front();
        chk(freq_len == LEN_W'(f.len), "R1", "fetch length", int'(freq_len), f.len);
        due = cyc + $urandom_range(lat_max, lat_min);
        if (due <= last_due) due = last_due + 1;
        last_due = due;
        resp_q.push_back('{int'(freq_tag), f.seq, due});
      end
    end
    p_fv = freq_valid; p_fr = fr; p_ftag = int'(freq_tag); p_flen = int'(freq_len);
    // write-back stream
    wr = ($urandom_range(99) < wr_pct);
    wb_ready = wr;
    if (wb_valid && wr) begin
      if (wexp_q.size() == 0) chk(1'b0, "R3", "unexpected write-back index", int'(wb_index), -1);
      else begin
        wexp_t w;
        w = wexp_q.pop_front();
        chk(wb_index == IDX_W'(w.seq % (1 << IDX_W)), "R6", "write-back index", int'(wb_index), w.seq % (1 << IDX_W));
        chk(wb_bytes == 5'(w.bytes), "R5", "write-back size", int'(wb_bytes), w.bytes);
        chk(got_cpl[w.seq] == need_cpl[w.seq], "R2 R7", "completions seen before write-back",
            got_cpl[w.seq], need_cpl[w.seq]);
      end
    end
    p_wv = wb_valid; p_wr = wr; p_widx = int'(wb_index); p_wbytes = int'(wb_bytes);
    // completion responder
    fdone_valid = 1'b0;
    if (!resp_hold && resp_q.size() > 0 && resp_q[0].due <= cyc) begin
      resp_t r;
      r = resp_q.pop_front();
      fdone_valid = 1'b1;
      fdone_tag = PTR_W'(r.tag);
      got_cpl[r.seq]++;
    end
    // descriptor stream
    desc_valid = 1'b0;
    if (stim_q.size() > 0) begin
      desc_valid = 1'b1;
      desc_kind  = 2'(stim_q[0].kind);
      desc_len   = LEN_W'(stim_q[0].len);
      desc_rs    = stim_q[0].rs;
      desc_seg   = stim_q[0].seg;
      if (desc_ready) accept(stim_q.pop_front());
    end
  endtask

  task automatic run_idle(input int limit, input string req);
    int n;
    n = 0;
    while ((stim_q.size() + fexp_q.size() + wexp_q.size() + resp_q.size()) != 0 && n < limit) begin
      step(); n++;
    end
    chk(n < limit, req, "work still pending after limit", n, limit);
    repeat (4) step();
  endtask

  task automatic push(input int kind, input int len, input bit rs, input bit seg);
    stim_q.push_back('{kind, len, rs, seg});
  endtask

  initial begin : watchdog
    while (cyc < 150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(desc_ready == 1'b1, "R10", "desc_ready after reset", int'(desc_ready), 1);
    chk(freq_valid == 1'b0, "R10", "freq_valid after reset", int'(freq_valid), 0);
    chk(wb_valid == 1'b0, "R10", "wb_valid after reset", int'(wb_valid), 0);

    // R1: splitting, legacy size
    wb_thresh = 0;
    push(0, 64, 1, 0);
    push(0, 600, 1, 1);
    push(0, 512, 1, 1);
    push(0, 100, 1, 1);
    push(0, 1000, 1, 0);
    run_idle(400, "R1");

    // R3: descriptors without report status
    push(0, 80, 0, 0);
    push(1, 0, 0, 0);
    push(0, 300, 1, 1);
    push(2, 0, 0, 0);
    push(0, 20, 0, 1);
    push(0, 48, 1, 0);
    run_idle(400, "R3");

    // R4: no-data descriptors complete without any fetch completion
    resp_hold = 1'b1;
    push(1, 0, 1, 0);
    run_idle(20, "R4");
    push(2, 0, 1, 0);
    push(0, 0, 1, 1);
    push(3, 40, 1, 0);
    run_idle(30, "R4");
    resp_hold = 1'b0;

    // R7: legacy data right after a segmentation send, slow completions
    lat_min = 8; lat_max = 14;
    push(0, 700, 1, 1);
    push(0, 40, 1, 0);
    push(1, 0, 1, 0);
    push(0, 900, 1, 1);
    push(0, 12, 1, 0);
    run_idle(600, "R7");
    lat_min = 1; lat_max = 4;

    // R5: full write-back size, then back to status byte
    wb_thresh = 3;
    push(0, 128, 1, 0);
    push(1, 0, 1, 0);
    push(0, 513, 1, 1);
    run_idle(400, "R5");
    wb_thresh = 1;
    push(2, 0, 1, 0);
    run_idle(100, "R5");
    wb_thresh = 0;
    push(0, 33, 1, 0);
    run_idle(100, "R5");

    // R8: fill the queue while completions are withheld
    resp_hold = 1'b1;
    for (int i = 0; i < DEPTH + 2; i++) push(0, 32, 1, 0);
    repeat (30) step();
    chk(desc_ready == 1'b0, "R8", "desc_ready with full queue", int'(desc_ready), 0);
    chk(stim_q.size() == 2, "R8", "descriptors still waiting", stim_q.size(), 2);
    chk(wb_valid == 1'b0, "R8 R2", "write-back with completions withheld", int'(wb_valid), 0);
    resp_hold = 1'b0;
    run_idle(400, "R8");

    // R9 and mixed traffic with random back-pressure
    fr_pct = 55; wr_pct = 45; lat_min = 1; lat_max = 9;
    for (int i = 0; i < 80; i++) begin
      int k;
      k = $urandom_range(5);
      if (i % 17 == 5) wb_thresh = TH_W'($urandom_range(2));
      if (k <= 2) push(0, $urandom_range(1200, 1), $urandom_range(1), $urandom_range(1));
      else push(k - 2, 0, $urandom_range(1), 0);
      run_idle(3000, "R9");
    end
    fr_pct = 100; wr_pct = 100;
    for (int i = 0; i < 40; i++)
      push((i % 3 == 1) ? 1 : 0, 40 + 37 * i, (i % 4) != 3, (i % 2) == 0);
    run_idle(4000, "R6");

    chk(wexp_q.size() == 0, "R6", "write-backs outstanding at end", wexp_q.size(), 0);
    chk(resp_q.size() == 0, "R2", "completions outstanding at end", resp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule